// File: doc/BRIEF.md
# Snoop Bus Request-Phase Sequencer

This block steps each request of a snooping split-transaction bus through a fixed five-cycle request phase:
1. The caches present request lines to an arbiter.
2. One winner is granted and a table tag is broadcast, so that every cache can open an entry under that tag.
3. The winner's command/address word appears on the shared bus.
4. A snoop cycle follows, in which the request puts nothing on the bus.
5. An acknowledge cycle follows, in which every cache reports whether its snoop finished.

When any cache reports that it is not finished, the block raises a late-snoop flag carrying that request's tag. The snoop result can then be delivered later.

Requests overlap. A new grant can be issued every cycle while earlier requests are still in their bus, snoop or acknowledge cycles, so up to five requests are in flight at once. Tags are handed out in grant order, and that order is the global ordering of the system. An external table-full input stops new grants while every tag is in use. The response and data phases are handled elsewhere.

Top module: `snoop_req_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every output is zero. The first tag issued after reset is 0.
- R2: Cycle n is the arbitration cycle. If any eligible cache requests in cycle n and tableFull is low in cycle n, then in cycle n+1 `grantVec` has exactly one bit set, for a cache that was requesting in cycle n. Otherwise `grantVec` is zero in cycle n+1.
- R3: Arbitration is round-robin. The search starts at the cache after the previous winner, wrapping from the last cache back to cache 0. After reset, cache 0 has the highest priority.
- R4: A cache whose grant bit is high in cycle n is not eligible in cycle n. Its still-asserted request line cannot win it a second, back-to-back grant.
- R5: If tableFull is high in cycle n, no grant and no tag appear in cycle n+1, and no tag value is used up.
- R6: `tagValid` is high exactly in the cycles that carry a grant. `tagBus` then holds the next tag, counting up by one per grant and wrapping modulo 2^TAG_W. `tagBus` is zero when `tagValid` is low.
- R7: For a grant shown in cycle g, `busValid` is high in cycle g+1. `busCmdAddr` then holds the winner's slice of `cmdAddr` as sampled in cycle g: slice i is bits [i*CA_W +: CA_W]. `busCmdAddr` is zero whenever `busValid` is low.
- R8: A request drives the bus only in cycle g+1. In its snoop cycle g+2 it contributes nothing, so `busValid` is low in g+2 unless a different request was granted in cycle g+1.
- R9: `snoopDone` (bit i from cache i, 1 = result ready) is sampled in cycle g+3. If any bit is 0, then in cycle g+4 `lateValid` is high and `lateTag` holds the tag issued in cycle g. Otherwise, and in every cycle without such a request, both outputs are zero.
- R10: Requests overlap. With at least two caches requesting continuously and tableFull low, a grant is issued in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqVec | input | NUM_CACHES | Request line from each cache |
| cmdAddr | input | NUM_CACHES*CA_W | Command/address word of each cache, slice i for cache i |
| snoopDone | input | NUM_CACHES | Snoop-ready acknowledge from each cache |
| tableFull | input | 1 | Tag table has no free entry |
| grantVec | output | NUM_CACHES | One-hot grant (resolution cycle) |
| tagValid | output | 1 | Tag broadcast is valid |
| tagBus | output | TAG_W | Tag assigned to the granted request |
| busValid | output | 1 | Command/address bus carries a request |
| busCmdAddr | output | CA_W | Command/address bus |
| lateValid | output | 1 | A request's snoop did not finish in time |
| lateTag | output | TAG_W | Tag of the late request |

## Verification
The properties assume that a cache keeps its request line high until it sees its grant, and drops it in the following cycle. They also assume that tableFull and snoopDone are stable across the clock edge that samples them. The stimulus drives every input at the falling edge. It keeps each request pending until the modelled grant appears, and it deasserts that request one cycle later, so the masking of a still-asserted line is exercised on every grant. All sixteen request patterns of the four-cache setup are swept as single arrivals. These are followed by overlapping arrivals with bursts of tableFull, periodic incomplete snoop acknowledges, and a saturated stretch in which every cache requests continuously.

// File: rtl/snoop_req_pkg.sv
package snoop_req_pkg;
  // Strobes from the sequencing control to the datapath.
  typedef struct packed {
    logic capture;   // resolution cycle: latch winner's command/address
    logic ackSlot;   // acknowledge cycle: evaluate snoopDone
  } stageStrobes_t;
endpackage

// File: rtl/snoop_rr_arbiter.sv
module snoop_rr_arbiter #(
  parameter int NUM_CACHES = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CACHES-1:0]         eligible,
  input  logic                          advance,
  output logic                          anyWin,
  output logic [$clog2(NUM_CACHES)-1:0] winIdx
);
  localparam int IDX_W = $clog2(NUM_CACHES);

  logic [IDX_W-1:0] lastQ;

  // Search starts one past the previous winner, wrapping around.
  always_comb begin
    int cand;
    anyWin = 1'b0;
    winIdx = '0;
    cand   = 0;
    for (int k = 1; k <= NUM_CACHES; k++) begin
      cand = (int'(lastQ) + k) % NUM_CACHES;
      if (!anyWin && eligible[cand]) begin
        anyWin = 1'b1;
        winIdx = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)        lastQ <= IDX_W'(NUM_CACHES - 1);
    else if (advance) lastQ <= winIdx;
  end
endmodule

// File: rtl/snoop_req_ctrl.sv
module snoop_req_ctrl
  import snoop_req_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int TAG_W      = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CACHES-1:0]         reqVec,
  input  logic                          tableFull,
  output logic [NUM_CACHES-1:0]         grantVec,
  output logic                          tagValid,
  output logic [TAG_W-1:0]              tagBus,
  output logic [$clog2(NUM_CACHES)-1:0] winIdx,
  output stageStrobes_t                 strobes
);
  localparam int IDX_W  = $clog2(NUM_CACHES);
  localparam int STAGES = 5;

  logic [NUM_CACHES-1:0] eligible;
  logic                  anyWin;
  logic [IDX_W-1:0]      winNow;
  logic                  fire;
  logic [TAG_W-1:0]      tagCnt;
  logic [STAGES:2]       stageV;   // stageV[k] : a request sits in stage k

  // The cache holding the grant this cycle has not dropped its line yet.
  assign eligible = reqVec & ~grantVec;
  assign fire     = anyWin & ~tableFull;

  snoop_rr_arbiter #(.NUM_CACHES(NUM_CACHES)) arb_i (
    .clk      (clk),
    .rstN     (rstN),
    .eligible (eligible),
    .advance  (fire),
    .anyWin   (anyWin),
    .winIdx   (winNow)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantVec <= '0;
      tagBus   <= '0;
      tagCnt   <= '0;
      winIdx   <= '0;
      stageV[2] <= 1'b0;
    end else begin
      stageV[2] <= fire;
      grantVec <= fire ? ({{(NUM_CACHES-1){1'b0}}, 1'b1} << winNow) : '0;
      tagBus   <= fire ? tagCnt : '0;
      tagCnt   <= tagCnt + TAG_W'(fire);
      if (fire) winIdx <= winNow;
    end
  end

  // Valid bits ride along the later stages.
  for (genvar s = 3; s <= STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stageV[s] <= 1'b0;
      else       stageV[s] <= stageV[s-1];
    end
  end

  assign tagValid        = stageV[2];
  assign strobes.capture = stageV[2];
  assign strobes.ackSlot = stageV[STAGES];
endmodule

// File: rtl/snoop_req_datapath.sv
module snoop_req_datapath
  import snoop_req_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int TAG_W      = 3,
  parameter int CA_W       = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  stageStrobes_t                 strobes,
  input  logic [$clog2(NUM_CACHES)-1:0] winIdx,
  input  logic [TAG_W-1:0]              tagIn,
  input  logic [NUM_CACHES*CA_W-1:0]    cmdAddr,
  input  logic [NUM_CACHES-1:0]         snoopDone,
  output logic                          busValid,
  output logic [CA_W-1:0]               busCmdAddr,
  output logic                          lateValid,
  output logic [TAG_W-1:0]              lateTag
);
  localparam int TAG_STAGES = 3;   // bus, snoop, acknowledge

  logic [TAG_W-1:0] tagPipe [TAG_STAGES+1];
  logic             notReady;

  assign tagPipe[0] = tagIn;

  for (genvar s = 1; s <= TAG_STAGES; s++) begin : g_tag
    always_ff @(posedge clk) begin
      if (!rstN) tagPipe[s] <= '0;
      else       tagPipe[s] <= tagPipe[s-1];
    end
  end

  assign notReady = strobes.ackSlot & ~(&snoopDone);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busValid   <= 1'b0;
      busCmdAddr <= '0;
      lateValid  <= 1'b0;
      lateTag    <= '0;
    end else begin
      busValid   <= strobes.capture;
      busCmdAddr <= strobes.capture ? cmdAddr[int'(winIdx)*CA_W +: CA_W] : '0;
      lateValid  <= notReady;
      lateTag    <= notReady ? tagPipe[TAG_STAGES] : '0;
    end
  end
endmodule

// File: rtl/snoop_req_sequencer.sv
module snoop_req_sequencer
  import snoop_req_pkg::*;
#(
  parameter int NUM_CACHES = 4,
  parameter int TAG_W      = 3,
  parameter int CA_W       = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CACHES-1:0]      reqVec,
  input  logic [NUM_CACHES*CA_W-1:0] cmdAddr,
  input  logic [NUM_CACHES-1:0]      snoopDone,
  input  logic                       tableFull,
  output logic [NUM_CACHES-1:0]      grantVec,
  output logic                       tagValid,
  output logic [TAG_W-1:0]           tagBus,
  output logic                       busValid,
  output logic [CA_W-1:0]            busCmdAddr,
  output logic                       lateValid,
  output logic [TAG_W-1:0]           lateTag
);
  localparam int IDX_W = $clog2(NUM_CACHES);

  stageStrobes_t    strobes;
  logic [IDX_W-1:0] winIdx;

  snoop_req_ctrl #(.NUM_CACHES(NUM_CACHES), .TAG_W(TAG_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqVec    (reqVec),
    .tableFull (tableFull),
    .grantVec  (grantVec),
    .tagValid  (tagValid),
    .tagBus    (tagBus),
    .winIdx    (winIdx),
    .strobes   (strobes)
  );

  snoop_req_datapath #(.NUM_CACHES(NUM_CACHES), .TAG_W(TAG_W), .CA_W(CA_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .winIdx     (winIdx),
    .tagIn      (tagBus),
    .cmdAddr    (cmdAddr),
    .snoopDone  (snoopDone),
    .busValid   (busValid),
    .busCmdAddr (busCmdAddr),
    .lateValid  (lateValid),
    .lateTag    (lateTag)
  );
endmodule

// File: rtl/snoop_req_sequencer_chk.sv
module snoop_req_sequencer_chk #(
  parameter int NUM_CACHES = 4,
  parameter int TAG_W      = 3,
  parameter int CA_W       = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_CACHES-1:0] reqVec,
  input logic                  tableFull,
  input logic [NUM_CACHES-1:0] grantVec,
  input logic                  tagValid,
  input logic [TAG_W-1:0]      tagBus,
  input logic                  busValid,
  input logic [CA_W-1:0]       busCmdAddr,
  input logic                  lateValid
);
  logic [TAG_W-1:0] expTag;

  always_ff @(posedge clk) begin
    if (!rstN)         expTag <= '0;
    else if (tagValid) expTag <= expTag + 1'b1;
  end

  a_r2_onehot_grant: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));

  a_r2_grant_was_requested: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec != '0) |-> (($past(reqVec) & grantVec) != '0));

  a_r4_no_repeat_grant: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec != '0) |=> ((grantVec & $past(grantVec)) == '0));

  a_r5_full_blocks_grant: assert property (@(posedge clk) disable iff (!rstN)
    tableFull |=> (!tagValid && grantVec == '0));

  a_r6_tag_sequence: assert property (@(posedge clk) disable iff (!rstN)
    tagValid |-> (tagBus == expTag));

  a_r6_tag_with_grant: assert property (@(posedge clk) disable iff (!rstN)
    tagValid == (grantVec != '0));

  a_r7_bus_follows_grant: assert property (@(posedge clk) disable iff (!rstN)
    tagValid |=> busValid);

  a_r7_idle_bus_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> (busCmdAddr == '0));

  a_r9_late_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    lateValid |-> $past(tagValid, 4));
endmodule

bind snoop_req_sequencer snoop_req_sequencer_chk #(
  .NUM_CACHES(NUM_CACHES), .TAG_W(TAG_W), .CA_W(CA_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .reqVec     (reqVec),
  .tableFull  (tableFull),
  .grantVec   (grantVec),
  .tagValid   (tagValid),
  .tagBus     (tagBus),
  .busValid   (busValid),
  .busCmdAddr (busCmdAddr),
  .lateValid  (lateValid)
);

// File: tb/snoop_req_sequencer_tb_top.sv
module snoop_req_sequencer_tb_top;
  localparam int N     = 4;
  localparam int TW    = 3;
  localparam int CW    = 8;
  localparam int NCYC  = 600;

  logic            clk = 1'b0;
  logic            rstN;
  logic [N-1:0]    reqVec;
  logic [N*CW-1:0] cmdAddr;
  logic [N-1:0]    snoopDone;
  logic            tableFull;
  logic [N-1:0]    grantVec;
  logic            tagValid;
  logic [TW-1:0]   tagBus;
  logic            busValid;
  logic [CW-1:0]   busCmdAddr;
  logic            lateValid;
  logic [TW-1:0]   lateTag;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;   // 125 MHz

  snoop_req_sequencer #(.NUM_CACHES(N), .TAG_W(TW), .CA_W(CW)) dut_i (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .cmdAddr(cmdAddr),
    .snoopDone(snoopDone), .tableFull(tableFull), .grantVec(grantVec),
    .tagValid(tagValid), .tagBus(tagBus), .busValid(busValid),
    .busCmdAddr(busCmdAddr), .lateValid(lateValid), .lateTag(lateTag)
  );

  // Expected outputs per cycle, ring of 8 slots.
  logic [N-1:0]  eGv  [8];
  logic          eTv  [8];
  logic [TW-1:0] eTag [8];
  logic          eBv  [8];
  logic [CW-1:0] eBus [8];
  logic          eLv  [8];
  logic [TW-1:0] eLtag[8];
  int            eWin [8];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0]  pending;
    logic [N-1:0]  reqDrive;
    logic [N-1:0]  arrivals;
    logic [N-1:0]  elig;
    logic [N-1:0]  snp;
    logic [CW-1:0] ca [N];
    logic          full;
    int            lastWin;
    logic [TW-1:0] nextTag;
    int            run;
    int            maxRun;
    int            s, n, old, w;

    for (int i = 0; i < 8; i++) begin
      eGv[i] = '0; eTv[i] = 1'b0; eTag[i] = '0; eBv[i] = 1'b0;
      eBus[i] = '0; eLv[i] = 1'b0; eLtag[i] = '0; eWin[i] = 0;
    end
    pending = '0; lastWin = N - 1; nextTag = '0; run = 0; maxRun = 0;

    rstN = 1'b0; reqVec = '1; cmdAddr = '1; snoopDone = '0; tableFull = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs held at zero during reset, even with requests present
    check("R1", "grant in reset", 32'(grantVec), 0);
    check("R1", "tagValid in reset", 32'(tagValid), 0);
    check("R1", "bus in reset", {busValid, 8'(busCmdAddr)}, 0);
    check("R1", "late in reset", {lateValid, 8'(lateTag)}, 0);
    reqVec = '0; cmdAddr = '0; snoopDone = '1;
    rstN = 1'b1;

    for (int c = 0; c < NCYC; c++) begin
      s = c % 8; n = (c + 1) % 8; old = (c + 5) % 8;

      check("R2 R3 R4", $sformatf("grant c%0d", c), 32'(grantVec), 32'(eGv[s]));
      check("R5 R6", $sformatf("tagValid c%0d", c), 32'(tagValid), 32'(eTv[s]));
      check("R1 R6", $sformatf("tag c%0d", c), 32'(tagBus), 32'(eTag[s]));
      check("R8", $sformatf("busValid c%0d", c), 32'(busValid), 32'(eBv[s]));
      check("R7", $sformatf("bus c%0d", c), 32'(busCmdAddr), 32'(eBus[s]));
      check("R9", $sformatf("late c%0d", c), {lateValid, 8'(lateTag)},
            {eLv[s], 8'(eLtag[s])});

      if (grantVec != '0) run++; else run = 0;
      if (run > maxRun) maxRun = run;

      w = (c + 2) % 8;
      eGv[w] = '0; eTv[w] = 1'b0; eTag[w] = '0; eBv[w] = 1'b0;
      eBus[w] = '0; eLv[w] = 1'b0; eLtag[w] = '0; eWin[w] = 0;

      // Stimulus phases: single-pattern sweep, mixed overlap, saturation.
      if (c < 200) begin
        arrivals = (c % 12 == 0) ? N'((c / 12) % 16) : '0;
        full     = (c % 12 == 5);
      end else if (c < 540) begin
        arrivals = N'((c * 7) % 16);
        full     = ((c % 9) < 2);
      end else begin
        arrivals = '1;
        full     = 1'b0;
      end
      snp = (c % 5 == 2) ? N'((c * 3) % 15) : '1;
      for (int i = 0; i < N; i++) ca[i] = CW'(c * 13 + i * 53 + 7);

      reqDrive = pending;
      pending  = (pending & ~eGv[s]) | arrivals;

      elig = reqDrive & ~eGv[s];
      if (!full && elig != '0) begin
        for (int k = 1; k <= N; k++) begin
          if (elig[(lastWin + k) % N]) begin
            w = (lastWin + k) % N;
            break;
          end
        end
        eGv[n] = N'(1) << w; eTv[n] = 1'b1; eTag[n] = nextTag; eWin[n] = w;
        nextTag = nextTag + 1'b1;
        lastWin = w;
      end
      if (eTv[s]) begin
        eBv[n]  = 1'b1;
        eBus[n] = ca[eWin[s]];
      end
      if (eTv[old] && snp != '1) begin
        eLv[n]   = 1'b1;
        eLtag[n] = eTag[old];
      end

      reqVec    = reqDrive;
      for (int i = 0; i < N; i++) cmdAddr[i*CW +: CW] = ca[i];
      snoopDone = snp;
      tableFull = full;
      @(negedge clk);
    end

    // R10: back-to-back grants while several caches request
    check("R10", "longest run of consecutive grants >= 5",
          32'(maxRun >= 5), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule